// File: doc/BRIEF.md
# Event Time-Stamp Capture

This block records the time at which an external event happens. It watches one event source, which is either an asynchronous capture pin or a comparator result bit. The source is synchronized and can optionally be passed through a majority-free persistence filter. An edge detector then looks for a transition in the chosen direction. On a qualifying transition the block copies the current value of a free-running 16-bit counter, supplied as an input, into a capture register. In the same clock it raises a flag that doubles as an interrupt request.

Software reads the 16-bit capture register over an 8-bit path, low byte first. The low-byte read returns its byte at once and parks the matching high byte in a temporary latch. The following high-byte read returns that latch, so the two halves always belong to one capture even if a new capture lands between the reads. Reads are plain single-cycle strobes. The bus has no valid/ready handshake and no back-pressure, because a register read always completes in the cycle it is issued. The flag is cleared by a write-one strobe or by an interrupt acknowledge.

Top module: `evt_capture_top`

## Requirements
- R1: After reset the flag `cap_irq` is 0, the capture register holds 0 and `rd_data` is 0 while no read strobe is high.
- R2: `cfg_src_cmp`=0 selects `cap_pin` and `cfg_src_cmp`=1 selects `cmp_out`; transitions on the unselected source never cause a capture.
- R3: `cfg_rise`=1 captures on 0→1 transitions of the selected source and `cfg_rise`=0 on 1→0 transitions; transitions in the other direction cause no capture.
- R4: With the filter off, a source change made between two clock edges is captured on the third following rising edge, and the register receives the `cnt_val` present just before that edge.
- R5: `cap_irq` becomes 1 on the same clock edge that loads the capture register.
- R6: With `cfg_filt_en`=1 the capture happens four edges later than in R4 (seventh edge). A level on the synchronized source that lasts fewer than four clocks causes no capture.
- R7: While `rd_lo`=1, `rd_data` shows capture bits [7:0] and the edge latches bits [15:8] into the temporary byte. While `rd_hi`=1, `rd_data` shows the temporary byte, unaffected by later captures.
- R8: A one-cycle `flag_clr` or `irq_ack` pulse clears `cap_irq` when no capture occurs in that cycle.
- R9: If a capture happens in the same cycle as `flag_clr`, `cap_irq` stays 1.
- R10: If a capture happens in the same cycle as a low-byte read, that read returns the previous low byte, and the following high-byte read returns the previous high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture pin |
| cmp_out | input | 1 | Comparator result bit |
| cfg_src_cmp | input | 1 | Source select: 0 pin, 1 comparator |
| cfg_rise | input | 1 | Edge select: 1 rising, 0 falling |
| cfg_filt_en | input | 1 | Enable the persistence filter |
| cnt_val | input | 16 | Free-running counter value |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| flag_clr | input | 1 | Write-one clear of the capture flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| rd_data | output | 8 | Read data byte |
| cap_irq | output | 1 | Capture flag / interrupt request |

## Verification
A capture can coincide with a flag clear, and a capture can coincide with a low-byte read. The bench provokes each case by changing the source, counting two edges so that the capture is known to land on the next edge, and asserting `flag_clr` or `rd_lo` in exactly that cycle. For the clear, the flag must still read 1 and the register must hold the new stamp. For the read, the low byte and the following high byte must both come from the old stamp, and a fresh read must return the new one.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int N_BYTE = CNT_W / BYTE_W;
  typedef logic [CNT_W-1:0]  stamp_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/evt_conditioner.sv
module evt_conditioner #(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic filt_en,
  output logic lvl
);
  logic [SYNC_N-1:0] sy;
  logic              s;
  logic [FILT_N-2:0] hist;
  logic              filt;
  logic              agree;

  always_ff @(posedge clk) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[SYNC_N-2:0], raw};
  end
  assign s = sy[SYNC_N-1];

  generate
    if (FILT_N > 2) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[FILT_N-3:0], s};
      end
    end else begin : g_narrow
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= s;
      end
    end
  endgenerate

  assign agree = (&{hist, s}) | ~(|{hist, s});

  always_ff @(posedge clk) begin
    if (!rst_n)     filt <= 1'b0;
    else if (agree) filt <= s;
  end

  assign lvl = filt_en ? filt : s;

  // R6: a filtered level only rises after the sample before it was already high
  assert_filter_persist_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && $past(filt_en) && $rose(lvl)) |-> $past(hist[0]));
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign hit = (lvl ^ prev) & ~(lvl ^ rise_sel);

  assert_edge_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lvl == rise_sel) && ($past(lvl) != rise_sel));
endmodule

// File: rtl/cap_store.sv
module cap_store
  import evtcap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  stamp_t cnt,
  input  logic   clr_wr1,
  input  logic   ack,
  input  logic   rd_lo,
  input  logic   rd_hi,
  output byte_t  rd_data,
  output logic   flag
);
  stamp_t cap_q;
  byte_t  tmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (hit) cap_q <= cnt;
      if (hit)                  flag <= 1'b1;
      else if (clr_wr1 || ack)  flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     tmp_q <= '0;
    else if (rd_lo) tmp_q <= cap_q[CNT_W-1:BYTE_W];
  end

  always_comb begin
    rd_data = '0;
    if (rd_lo)      rd_data = cap_q[BYTE_W-1:0];
    else if (rd_hi) rd_data = tmp_q;
  end

  assert_stamp_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cap_q == $past(cnt));
  assert_flag_with_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && (clr_wr1 || ack)) |=> !flag);
  assert_capture_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_wr1) |=> flag);
  assert_temp_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> tmp_q == $past(cap_q[CNT_W-1:BYTE_W]));
  assert_reg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_q));
endmodule

// File: rtl/evt_capture_top.sv
module evt_capture_top
  import evtcap_pkg::*;
#(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic             cmp_out,
  input  logic             cfg_src_cmp,
  input  logic             cfg_rise,
  input  logic             cfg_filt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic             flag_clr,
  input  logic             irq_ack,
  output logic [BYTE_W-1:0] rd_data,
  output logic             cap_irq
);
  logic src_raw;
  logic lvl;
  logic hit;

  assign src_raw = cfg_src_cmp ? cmp_out : cap_pin;

  evt_conditioner #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_cond (
    .clk(clk), .rst_n(rst_n), .raw(src_raw), .filt_en(cfg_filt_en), .lvl(lvl));

  evt_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise_sel(cfg_rise), .hit(hit));

  cap_store u_store (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cnt(cnt_val),
    .clr_wr1(flag_clr), .ack(irq_ack), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rd_data(rd_data), .flag(cap_irq));
endmodule

// File: tb/evt_capture_top_tb_top.sv
module evt_capture_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0, cmp_out = 1'b0;
  logic        cfg_src_cmp = 1'b0, cfg_rise = 1'b1, cfg_filt_en = 1'b0;
  logic [15:0] cnt_val = 16'h0010;
  logic        rd_lo = 1'b0, rd_hi = 1'b0, flag_clr = 1'b0, irq_ack = 1'b0;
  logic [7:0]  rd_data;
  logic        cap_irq;
  int          n_chk = 0, n_fail = 0;
  localparam logic [15:0] STEP = 16'h0103;

  always #2 clk = ~clk;
  always_ff @(posedge clk) cnt_val <= cnt_val + STEP;

  evt_capture_top dut_i (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cmp_out(cmp_out),
    .cfg_src_cmp(cfg_src_cmp), .cfg_rise(cfg_rise), .cfg_filt_en(cfg_filt_en),
    .cnt_val(cnt_val), .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr),
    .irq_ack(irq_ack), .rd_data(rd_data), .cap_irq(cap_irq));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read16(output logic [15:0] v);
    rd_lo = 1'b1; #1; v[7:0] = rd_data;
    tick(1);
    rd_lo = 1'b0; rd_hi = 1'b1; #1; v[15:8] = rd_data;
    tick(1);
    rd_hi = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 flag", {15'd0, cap_irq}, 16'd0);
    chk("R1 idle bus", {8'd0, rd_data}, 16'd0);
    read16(v);
    chk("R1 register", v, 16'd0);
  endtask

  task automatic t_pin_rise();
    logic [15:0] c, v;
    cap_pin = 1'b1; c = cnt_val;
    tick(2);
    chk("R4 not yet", {15'd0, cap_irq}, 16'd0);
    tick(1);
    chk("R5 flag", {15'd0, cap_irq}, 16'd1);
    read16(v);
    chk("R4 stamp", v, c + 2*STEP);
    clear_flag();
    chk("R8 write-one clear", {15'd0, cap_irq}, 16'd0);
  endtask

  task automatic t_polarity();
    logic [15:0] c, v;
    cap_pin = 1'b0; tick(6);
    chk("R3 falling ignored", {15'd0, cap_irq}, 16'd0);
    cfg_rise = 1'b0; tick(1);
    cap_pin = 1'b1; tick(6);
    chk("R3 rising ignored", {15'd0, cap_irq}, 16'd0);
    cap_pin = 1'b0; c = cnt_val; tick(3);
    chk("R3 falling captured", {15'd0, cap_irq}, 16'd1);
    read16(v);
    chk("R3 stamp", v, c + 2*STEP);
    clear_flag();
    cfg_rise = 1'b1; tick(2);
  endtask

  task automatic t_source();
    logic [15:0] c, v;
    cfg_src_cmp = 1'b1; tick(4);
    cap_pin = 1'b1; tick(6);
    chk("R2 pin ignored", {15'd0, cap_irq}, 16'd0);
    cmp_out = 1'b1; c = cnt_val; tick(3);
    chk("R2 comparator captured", {15'd0, cap_irq}, 16'd1);
    read16(v);
    chk("R2 stamp", v, c + 2*STEP);
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    chk("R8 ack clear", {15'd0, cap_irq}, 16'd0);
    cmp_out = 1'b0; cap_pin = 1'b0; tick(4);
    clear_flag();
    cfg_src_cmp = 1'b0; tick(4);
  endtask

  task automatic t_filter();
    logic [15:0] c, v;
    cfg_filt_en = 1'b1; tick(6);
    cap_pin = 1'b1; tick(3); cap_pin = 1'b0; tick(10);
    chk("R6 short pulse rejected", {15'd0, cap_irq}, 16'd0);
    cap_pin = 1'b1; c = cnt_val;
    tick(6);
    chk("R6 not yet", {15'd0, cap_irq}, 16'd0);
    tick(1);
    chk("R6 captured", {15'd0, cap_irq}, 16'd1);
    read16(v);
    chk("R6 stamp", v, c + 6*STEP);
    clear_flag();
    cfg_filt_en = 1'b0; tick(2);
    cap_pin = 1'b0; tick(5);
    clear_flag();
  endtask

  task automatic t_clear_collide();
    logic [15:0] c, v;
    cap_pin = 1'b1; tick(4);
    chk("R9 flag preset", {15'd0, cap_irq}, 16'd1);
    cap_pin = 1'b0; tick(3);
    cap_pin = 1'b1; c = cnt_val; tick(2);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R9 capture wins", {15'd0, cap_irq}, 16'd1);
    read16(v);
    chk("R9 stamp", v, c + 2*STEP);
    clear_flag();
  endtask

  task automatic t_read_collide();
    logic [15:0] old, c, v, w;
    read16(old);
    cap_pin = 1'b0; tick(4); clear_flag();
    cap_pin = 1'b1; c = cnt_val; tick(2);
    rd_lo = 1'b1; #1; v[7:0] = rd_data;
    tick(1);
    rd_lo = 1'b0; rd_hi = 1'b1; #1; v[15:8] = rd_data;
    tick(1); rd_hi = 1'b0;
    chk("R10 old pair", v, old);
    chk("R7 capture seen", {15'd0, cap_irq}, 16'd1);
    read16(w);
    chk("R7 fresh read", w, c + 2*STEP);
    clear_flag();
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset();
    t_pin_rise();
    t_polarity();
    t_source();
    t_filter();
    t_clear_collide();
    t_read_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule